// File: doc/BRIEF.md
# Buried Logic Cell with Selectable Feedback

This block models one buried cell of a programmable logic array. Five product-term bits, one from the universal group and four from the regional group, are ORed into a single sum term. That sum drives one flip-flop, which can work as a D-type or a T-type. The cell drives no pin. Its only output is a feedback bit for the regional bus. A configuration bit chooses what that bit carries: the flip-flop state, or the raw sum term. The raw sum lets the array chain logic through the cell without spending a register stage.

The flip-flop has its own preset, reset and clock product terms. Its clock has two modes. In gated mode, the quadrant clock is ANDed with the clock term. In term mode, the clock term alone clocks the flip-flop. A rising edge of this effective clock is detected against the system clock. The flip-flop state is an enumerated machine with two states, `ST_LOW` and `ST_HIGH`, and four transitions:
- CLEAR goes to `ST_LOW` when the reset term is high.
- SET goes to `ST_HIGH` when the preset term is high.
- LOAD takes the sum term on a clock edge in D mode.
- TOGGLE flips the state on a clock edge in T mode when the sum term is high.

When no transition applies, the machine stays in its state.

Top module: `bcell_top`

## Requirements
- R1: The sum term is the OR of the universal term bit `pt_univ` and the four regional term bits `pt_reg`. Any single bit set makes it 1, and all bits clear make it 0.
- R2: With `cfg_fb_comb`=1, `fb_out` equals the sum term in the same cycle, with no register stage.
- R3: With `cfg_fb_comb`=0, `fb_out` shows the flip-flop state. A change appears after the system clock edge that updates the state.
- R4: In D mode (`cfg_tmode`=0), a rising edge of the effective clock loads the sum term into the flip-flop.
- R5: In T mode (`cfg_tmode`=1), a clock edge toggles the state when the sum term is 1 and holds it when the sum term is 0.
- R6: In term mode (`cfg_syncclk`=0), a rising edge of `clk_term` clocks the flip-flop whatever level `quad_clk` has.
- R7: In gated mode (`cfg_syncclk`=1), the effective clock is `quad_clk` AND `clk_term`. A `clk_term` edge while `quad_clk` is low does not clock the flip-flop.
- R8: A high `preset_term` forces the state high at the next system clock edge, and a high `reset_term` forces it low, both overriding any clock edge.
- R9: When preset and reset are high together, reset wins and the state goes low.
- R10: After `rst_n` low, the state is low, so `fb_out` in registered mode is 0.
- R11: While `cfg_fb_comb`=1, the flip-flop keeps being clocked. Switching back to registered mode shows the state it reached.
- R12: An effective clock held high gives exactly one update. Further sum changes have no effect until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all terms |
| rst_n | input | 1 | Active-low reset (power-up clear) |
| pt_univ | input | NUM_UNIV | Universal product-term bits |
| pt_reg | input | NUM_REG | Regional product-term bits |
| preset_term | input | 1 | Preset product term, high forces state high |
| reset_term | input | 1 | Reset product term, high forces state low |
| clk_term | input | 1 | Clock product term |
| quad_clk | input | 1 | Quadrant clock, used in gated mode |
| cfg_tmode | input | 1 | 0 selects D-type, 1 selects T-type |
| cfg_syncclk | input | 1 | 1 selects gated mode, 0 selects term mode |
| cfg_fb_comb | input | 1 | 1 feeds back the sum term, 0 feeds back the state |
| fb_out | output | 1 | Feedback bit to the regional bus |

## Verification
The bench builds the cell with its default term counts: one universal bit and four regional bits. This lets every one of the five term bits be driven alone and seen through the combinatorial feedback path. Both clock modes and both flip-flop types are covered. With only two flip-flop states, every transition can be reached from each state, including reset beating preset and a clock held high across changes of the sum term.

// File: rtl/bcell_pkg.sv
package bcell_pkg;
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } ff_state_t;
endpackage

// File: rtl/bcell_sum.sv
module bcell_sum #(
    parameter int NUM_UNIV = 1,
    parameter int NUM_REG  = 4
) (
    input  logic [NUM_UNIV-1:0] pt_univ,
    input  logic [NUM_REG-1:0]  pt_reg,
    output logic                sum_o
);
    localparam int NUM_TERMS = NUM_UNIV + NUM_REG;

    logic [NUM_TERMS-1:0] terms;
    logic [NUM_TERMS:0]   chain;

    assign terms    = {pt_reg, pt_univ};
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < NUM_TERMS; i++) begin : g_or
        assign chain[i+1] = chain[i] | terms[i];
    end

    assign sum_o = chain[NUM_TERMS];
endmodule

// File: rtl/bcell_clkedge.sv
module bcell_clkedge (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_term,
    input  logic quad_clk,
    input  logic cfg_syncclk,
    output logic edge_o
);
    logic eff_clk;
    logic eff_prev_q;

    assign eff_clk = cfg_syncclk ? (quad_clk & clk_term) : clk_term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eff_prev_q <= 1'b0;
        else        eff_prev_q <= eff_clk;
    end

    assign edge_o = eff_clk & ~eff_prev_q;

    // R12: a held clock cannot produce two edges in a row
    assert_single_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
    // R7: in gated mode no edge while the quadrant clock is low
    assert_gated_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_syncclk && !quad_clk) |-> !edge_o);
endmodule

// File: rtl/bcell_ff.sv
module bcell_ff
    import bcell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic sum_i,
    input  logic tmode_i,
    input  logic preset_i,
    input  logic reset_i,
    output logic q_o
);
    ff_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    // transitions: CLEAR, SET, LOAD, TOGGLE, else hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (reset_i)                           state_d = ST_LOW;
                else if (preset_i)                     state_d = ST_HIGH;
                else if (edge_i && !tmode_i && sum_i)  state_d = ST_HIGH;
                else if (edge_i && tmode_i && sum_i)   state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (reset_i)                           state_d = ST_LOW;
                else if (preset_i)                     state_d = ST_HIGH;
                else if (edge_i && !tmode_i && !sum_i) state_d = ST_LOW;
                else if (edge_i && tmode_i && sum_i)   state_d = ST_LOW;
            end
            default: state_d = ST_LOW;
        endcase
    end

    // output process
    always_comb begin
        q_o = (state_q == ST_HIGH);
    end

    assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_i |=> (state_q == ST_LOW));
    assert_preset_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_i && !reset_i) |=> (state_q == ST_HIGH));
    assert_hold_no_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_i && !preset_i && !reset_i) |=> $stable(state_q));
    assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && tmode_i && sum_i && !preset_i && !reset_i) |=> (state_q != $past(state_q)));
    assert_dload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !tmode_i && !preset_i && !reset_i) |=> (q_o == $past(sum_i)));
endmodule

// File: rtl/bcell_top.sv
module bcell_top #(
    parameter int NUM_UNIV = 1,
    parameter int NUM_REG  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_UNIV-1:0] pt_univ,
    input  logic [NUM_REG-1:0]  pt_reg,
    input  logic                preset_term,
    input  logic                reset_term,
    input  logic                clk_term,
    input  logic                quad_clk,
    input  logic                cfg_tmode,
    input  logic                cfg_syncclk,
    input  logic                cfg_fb_comb,
    output logic                fb_out
);
    logic sum_w;
    logic edge_w;
    logic q_w;

    bcell_sum #(.NUM_UNIV(NUM_UNIV), .NUM_REG(NUM_REG)) u_sum (
        .pt_univ (pt_univ),
        .pt_reg  (pt_reg),
        .sum_o   (sum_w)
    );

    bcell_clkedge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_term    (clk_term),
        .quad_clk    (quad_clk),
        .cfg_syncclk (cfg_syncclk),
        .edge_o      (edge_w)
    );

    bcell_ff u_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (edge_w),
        .sum_i    (sum_w),
        .tmode_i  (cfg_tmode),
        .preset_i (preset_term),
        .reset_i  (reset_term),
        .q_o      (q_w)
    );

    always_comb begin
        fb_out = cfg_fb_comb ? sum_w : q_w;
    end

    // R2: combinatorial feedback carries any set term bit
    assert_comb_fb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fb_comb && ((|pt_univ) || (|pt_reg))) |-> fb_out);
    // R1: no term set means a zero sum on the combinatorial path
    assert_sum_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fb_comb && !(|pt_univ) && !(|pt_reg)) |-> !fb_out);
endmodule

// File: tb/bcell_top_tb_top.sv
`timescale 1ns/1ps
module bcell_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [0:0] pt_univ;
    logic [3:0] pt_reg;
    logic       preset_term, reset_term, clk_term, quad_clk;
    logic       cfg_tmode, cfg_syncclk, cfg_fb_comb;
    logic       fb_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_q    = 1'b0;

    always #2 clk = ~clk;

    bcell_top dut_i (
        .clk(clk), .rst_n(rst_n), .pt_univ(pt_univ), .pt_reg(pt_reg),
        .preset_term(preset_term), .reset_term(reset_term), .clk_term(clk_term),
        .quad_clk(quad_clk), .cfg_tmode(cfg_tmode), .cfg_syncclk(cfg_syncclk),
        .cfg_fb_comb(cfg_fb_comb), .fb_out(fb_out)
    );

    task automatic check(input string req, input logic act, input logic expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic set_sum(input logic v);
        pt_univ = 1'b0;
        pt_reg  = v ? 4'b0100 : 4'b0000;
    endtask

    // pulse clk_term for one system cycle; inputs change at negedge
    task automatic pulse_term();
        @(negedge clk); clk_term = 1'b1;
        @(negedge clk); clk_term = 1'b0;
        @(negedge clk);
    endtask

    task automatic look_q(input string req, input logic expv);
        cfg_fb_comb = 1'b0;
        #0.1;
        check(req, fb_out, expv);
    endtask

    task automatic t_reset();
        look_q("R10 reset state", 1'b0);
    endtask

    task automatic t_sum();
        cfg_fb_comb = 1'b1;
        pt_univ = 1'b0; pt_reg = 4'b0000; #0.1;
        check("R1 all clear", fb_out, 1'b0);
        pt_univ = 1'b1; #0.1;
        check("R1 universal bit", fb_out, 1'b1);
        pt_univ = 1'b0;
        for (int i = 0; i < 4; i++) begin
            pt_reg = 4'b0001 << i; #0.1;
            check($sformatf("R1 R2 regional bit %0d", i), fb_out, 1'b1);
        end
        pt_reg = 4'b0000; #0.1;
        check("R2 same cycle drop", fb_out, 1'b0);
    endtask

    task automatic t_dload();
        cfg_tmode = 1'b0; cfg_syncclk = 1'b0; cfg_fb_comb = 1'b0;
        @(negedge clk); set_sum(1'b1); quad_clk = 1'b0;
        pulse_term(); exp_q = 1'b1;
        look_q("R4 R6 load one", exp_q);
        set_sum(1'b0); #0.1;
        check("R3 no change before edge", fb_out, exp_q);
        pulse_term(); exp_q = 1'b0;
        look_q("R4 load zero", exp_q);
        quad_clk = 1'b1; set_sum(1'b1);
        pulse_term(); exp_q = 1'b1;
        look_q("R6 quad_clk ignored", exp_q);
    endtask

    task automatic t_toggle();
        cfg_tmode = 1'b1; cfg_syncclk = 1'b0;
        set_sum(1'b1);
        pulse_term(); exp_q = ~exp_q;
        look_q("R5 toggle 1", exp_q);
        pulse_term(); exp_q = ~exp_q;
        look_q("R5 toggle 2", exp_q);
        set_sum(1'b0);
        pulse_term();
        look_q("R5 hold with sum 0", exp_q);
    endtask

    task automatic t_gated();
        cfg_tmode = 1'b0; cfg_syncclk = 1'b1;
        @(negedge clk); quad_clk = 1'b0; set_sum(~exp_q);
        pulse_term();
        look_q("R7 blocked by quad_clk low", exp_q);
        quad_clk = 1'b1;
        pulse_term(); exp_q = ~exp_q;
        look_q("R7 clocks with quad_clk high", exp_q);
        quad_clk = 1'b0;
    endtask

    task automatic t_held();
        cfg_tmode = 1'b0; cfg_syncclk = 1'b0;
        @(negedge clk); set_sum(1'b1); clk_term = 1'b1;
        @(negedge clk); exp_q = 1'b1;
        set_sum(1'b0);
        @(negedge clk); @(negedge clk);
        look_q("R12 held clock one update", exp_q);
        clk_term = 1'b0;
        @(negedge clk);
        look_q("R12 fall no update", exp_q);
    endtask

    task automatic t_pr_rs();
        cfg_tmode = 1'b0; cfg_syncclk = 1'b0;
        @(negedge clk); reset_term = 1'b1;
        @(negedge clk); reset_term = 1'b0; exp_q = 1'b0;
        look_q("R8 reset low", exp_q);
        set_sum(1'b0); preset_term = 1'b1; clk_term = 1'b1;
        @(negedge clk); preset_term = 1'b0; clk_term = 1'b0; exp_q = 1'b1;
        look_q("R8 preset overrides load", exp_q);
        preset_term = 1'b1; reset_term = 1'b1;
        @(negedge clk); preset_term = 1'b0; reset_term = 1'b0; exp_q = 1'b0;
        look_q("R9 reset wins", exp_q);
    endtask

    task automatic t_comb_updates();
        cfg_tmode = 1'b0; cfg_syncclk = 1'b0;
        cfg_fb_comb = 1'b1; set_sum(1'b1);
        pulse_term(); exp_q = 1'b1;
        set_sum(1'b0); #0.1;
        check("R11 comb path shows sum", fb_out, 1'b0);
        look_q("R11 state updated in comb mode", exp_q);
    endtask

    initial begin
        rst_n = 1'b0; pt_univ = '0; pt_reg = '0;
        preset_term = 1'b0; reset_term = 1'b0; clk_term = 1'b0; quad_clk = 1'b0;
        cfg_tmode = 1'b0; cfg_syncclk = 1'b0; cfg_fb_comb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sum();
        t_dload();
        t_toggle();
        t_gated();
        t_held();
        t_pr_rs();
        t_comb_updates();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule